// File: doc/BRIEF.md
# Packetized SPI Bridge Command Engine

This block sits between a packet transport from a host and a SPI controller that drives an external flash device. It takes each host command packet of up to 64 bytes as a byte stream with an end-of-packet marker, stores it, and decodes the 16-bit little-endian identifier and header fields. Every header is range-checked. A valid request becomes a chunk request to the downstream SPI controller. A fault becomes a 4-byte status response.

A write longer than one packet can carry arrives as a start packet followed by continuation packets. The engine has two protocol states, IDLE and WRITING. In WRITING it requires each continuation to carry a data index equal to the number of bytes already forwarded. It keeps the chip-select held across chunks until the last byte of the write has been sent. Configuration queries, short writes, and reads (with or without a short write before them) complete without leaving IDLE. The SPI controller reads chunk payload bytes straight from the packet buffer through an index port.

Top module: `pkt_spi_bridge`

## Requirements
- R1: After reset the engine accepts bytes (`rx_ready`=1), has no response pending (`rsp_valid`=0) and no chunk request (`chk_req`=0).
- R2: In IDLE, a packet of exactly 2 bytes with identifier 0 is answered with an 8-byte response. Its little-endian 16-bit fields are, in order: identifier 1, maximum write 270, maximum read 2045, feature bitmap 0.
- R3: Identifiers are bytes 0 (low) and 1 (high), with start = 2 and continue = 3. In IDLE, a packet shorter than 2 bytes gives status 0x8000. Any other packet that is not a start packet, including identifier 4 and an identifier 0 whose length is not 2, gives status 0x000A. A start packet shorter than 6 bytes also gives status 0x000A.
- R4: A start packet carries the write count in bytes 2-3 and the read count in bytes 4-5, both little-endian. A read count above 2045 gives status 0x0004. This check comes before any write-count check.
- R5: A start packet gives status 0x0003 in any of these cases: the write count exceeds 270; the write count is 58 or less and differs from the packet length minus 6; the read count is nonzero and the write count exceeds 58.
- R6: An accepted start packet whose write count is 58 or less issues one chunk with that write length, the full read count, chip-select released, and payload at buffer offset 6. When the chunk succeeds, the engine answers with status 0. If both counts are zero, it answers with status 0 and issues no chunk.
- R7: An accepted start packet with a write count above 58 clears the running offset and forwards the first 58 bytes with chip-select held. It sends no response and moves to WRITING.
- R8: In WRITING, a continue packet whose data index (bytes 2-3) equals the running offset forwards its payload from buffer offset 4. Chip-select stays held until the running total reaches the write count. The chunk that completes the write releases chip-select, is answered with status 0, and returns the engine to IDLE.
- R9: In WRITING, status 0x0008 is returned and the engine goes to IDLE for any of these: a packet that is not a continue packet, a packet of 4 bytes or fewer, or a data index that differs from the running offset.
- R10: A chunk that completes with a nonzero controller status is answered with that status and returns the engine to IDLE. Every status response is 4 bytes: identifier 5 in bytes 0-1, the status in bytes 2-3, and zeros in the upper bytes.
- R11: While `bridge_en` is low, every packet is answered with status 0x0005, no chunk is issued, and the engine returns to IDLE.
- R12: `chk_req` stays high until `chk_done`, drops the cycle after it, and no packet byte is accepted while a chunk is outstanding.
- R13: `rsp_valid` is a single-cycle pulse, and `rsp_len` is 4 or 8 whenever it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bridge_en | input | 1 | Bridge enabled; when low, every packet gets status 0x0005 |
| rx_valid | input | 1 | Packet byte valid |
| rx_data | input | 8 | Packet byte |
| rx_last | input | 1 | Marks the final byte of a packet |
| rx_ready | output | 1 | Engine can take packet bytes |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_len | output | 4 | Response length in bytes (4 or 8) |
| rsp_data | output | 64 | Response bytes, byte 0 in bits 7:0 |
| chk_req | output | 1 | Chunk request to SPI controller, held until done |
| chk_wr_len | output | log2(MAX_PKT) (6) | Bytes to write in this chunk |
| chk_rd_len | output | 16 | Bytes to read after the write |
| chk_hold_cs | output | 1 | Keep chip-select asserted after this chunk |
| chk_base | output | log2(MAX_PKT) (6) | Buffer offset of the first payload byte |
| chk_done | input | 1 | Chunk finished |
| chk_status | input | 16 | Chunk result status, 0 = success |
| spi_rd_idx | input | log2(MAX_PKT) (6) | Packet buffer read index |
| spi_rd_byte | output | 8 | Packet buffer byte at `spi_rd_idx` |

## Verification
The bench goes after the limits on each side: a 58-byte write that fits exactly, a 59-byte write that needs a one-byte continuation, a read of exactly 2045 against one of 2046, and a zero-length request that must not reach the controller. A design with an off-by-one limit would accept a 2046-byte read or split a 58-byte write. A design that checked the write count before the read count would report 0x0003 where 0x0004 is required. In WRITING, the bench sends a wrong data index, a header-only continue, a stray start and a restart identifier, then a configuration query. An engine that failed to drop back to IDLE would answer that query with 0x0008. The bench also disables the bridge in the middle of a write and injects controller faults on a first and a single chunk. A design that kept a stale running offset would accept the continuation that follows, where status 0x000A is required.

// File: rtl/pkt_bridge_pkg.sv
// Shared constants and types for the packetized SPI bridge engine.
// Assumes 16-bit little-endian header fields throughout.
package pkt_bridge_pkg;

    // Packet identifiers
    localparam logic [15:0] PID_GET_CFG    = 16'd0;
    localparam logic [15:0] PID_CFG_RSP    = 16'd1;
    localparam logic [15:0] PID_XFER_START = 16'd2;
    localparam logic [15:0] PID_XFER_CONT  = 16'd3;
    localparam logic [15:0] PID_RSP_START  = 16'd5;

    // Status codes returned to the host
    localparam logic [15:0] ST_OK         = 16'h0000;
    localparam logic [15:0] ST_WR_BAD     = 16'h0003;
    localparam logic [15:0] ST_RD_BAD     = 16'h0004;
    localparam logic [15:0] ST_OFF        = 16'h0005;
    localparam logic [15:0] ST_UNEXPECTED = 16'h0008;
    localparam logic [15:0] ST_RUNT       = 16'h000A;
    localparam logic [15:0] ST_UNKNOWN    = 16'h8000;

    // Header sizes in bytes
    localparam int START_HDR_BYTES = 6;
    localparam int CONT_HDR_BYTES  = 4;

    typedef enum logic [1:0] {PH_RECV, PH_EVAL, PH_CHUNK} phase_t;
    typedef enum logic {PS_IDLE, PS_WRITING} proto_t;
    typedef enum logic [1:0] {ACT_CONFIG, ACT_STATUS, ACT_CHUNK} action_t;

endpackage

// File: rtl/pkt_rx_buffer.sv
// Packet byte store. The first byte after reset, or after a byte marked
// last, starts a new packet at index 0. Bytes past MAX_PKT are dropped.
// Contents stay stable until the next packet starts, so the SPI controller
// can read chunk payload through the index port.
module pkt_rx_buffer #(
    parameter  int MAX_PKT = 64,
    localparam int IDX_W   = $clog2(MAX_PKT),
    localparam int LEN_W   = $clog2(MAX_PKT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_byte,
    input  logic             wr_last,
    output logic [LEN_W-1:0] pkt_len,
    output logic [15:0]      hdr_id,
    output logic [15:0]      hdr_a,
    output logic [15:0]      hdr_b,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_byte
);
    localparam logic [LEN_W-1:0] CAP = LEN_W'(MAX_PKT);

    logic [7:0]       mem [MAX_PKT];
    logic             fresh;
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] wpos;

    // Write position: restart at zero for the first byte of a packet
    assign wpos = fresh ? '0 : cnt;

    // Track packet length and packet boundaries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fresh <= 1'b1;
            cnt   <= '0;
        end else if (wr_en) begin
            fresh <= wr_last;
            cnt   <= (wpos < CAP) ? wpos + 1'b1 : wpos;
        end
    end

    // Store the byte while room remains
    always_ff @(posedge clk) begin
        if (wr_en && (wpos < CAP)) begin
            mem[wpos[IDX_W-1:0]] <= wr_byte;
        end
    end

    // Header fields and the payload read port
    always_comb begin
        pkt_len = cnt;
        hdr_id  = {mem[1], mem[0]};
        hdr_a   = {mem[3], mem[2]};
        hdr_b   = {mem[5], mem[4]};
        rd_byte = mem[rd_idx];
    end

endmodule

// File: rtl/pkt_hdr_check.sv
// Combinational header validator. Given the protocol state, the enable and
// the stored header, it picks one action: send the configuration, send a
// status, or issue a chunk described by length, read count, hold flag and
// payload offset. Check order follows the status priority of the protocol.
module pkt_hdr_check
    import pkt_bridge_pkg::*;
#(
    parameter  int MAX_PKT = 64,
    parameter  int MAX_WR  = 270,
    parameter  int MAX_RD  = 2045,
    localparam int IDX_W   = $clog2(MAX_PKT),
    localparam int LEN_W   = $clog2(MAX_PKT + 1)
) (
    input  logic             enabled,
    input  proto_t           proto,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic [15:0]      hdr_id,
    input  logic [15:0]      hdr_a,
    input  logic [15:0]      hdr_b,
    input  logic [15:0]      wr_total,
    input  logic [15:0]      wr_done,
    output action_t          dec_action,
    output logic [15:0]      dec_status,
    output logic             dec_start,
    output logic [IDX_W-1:0] dec_wr_len,
    output logic [15:0]      dec_rd_len,
    output logic             dec_hold,
    output logic [IDX_W-1:0] dec_base
);
    localparam logic [15:0]      START_PAY   = 16'(MAX_PKT - START_HDR_BYTES);
    localparam logic [IDX_W-1:0] START_PAY_N = IDX_W'(MAX_PKT - START_HDR_BYTES);
    localparam logic [15:0]      MAX_WR16    = 16'(MAX_WR);
    localparam logic [15:0]      MAX_RD16    = 16'(MAX_RD);
    localparam logic [LEN_W-1:0] CONT_HDR_N  = LEN_W'(CONT_HDR_BYTES);

    logic [15:0]      len16;
    logic [LEN_W-1:0] cont_pay;
    logic [16:0]      cont_sum;

    // Length views used by the checks
    always_comb begin
        len16    = 16'(pkt_len);
        cont_pay = pkt_len - CONT_HDR_N;
        cont_sum = {1'b0, wr_done} + 17'(cont_pay);
    end

    // Decision in status-priority order
    always_comb begin
        dec_action = ACT_STATUS;
        dec_status = ST_OK;
        dec_start  = 1'b0;
        dec_wr_len = '0;
        dec_rd_len = '0;
        dec_hold   = 1'b0;
        dec_base   = '0;
        if (!enabled) begin
            dec_status = ST_OFF;
        end else if (proto == PS_IDLE) begin
            if (len16 < 16'd2) begin
                dec_status = ST_UNKNOWN;
            end else if (hdr_id == PID_GET_CFG && len16 == 16'd2) begin
                dec_action = ACT_CONFIG;
            end else if (hdr_id != PID_XFER_START || len16 < 16'(START_HDR_BYTES)) begin
                dec_status = ST_RUNT;
            end else if (hdr_b > MAX_RD16) begin
                dec_status = ST_RD_BAD;
            end else if (hdr_a > MAX_WR16) begin
                dec_status = ST_WR_BAD;
            end else if (hdr_a <= START_PAY && hdr_a != len16 - 16'(START_HDR_BYTES)) begin
                dec_status = ST_WR_BAD;
            end else if (hdr_b != 16'd0 && hdr_a > START_PAY) begin
                dec_status = ST_WR_BAD;
            end else if (hdr_a == 16'd0 && hdr_b == 16'd0) begin
                dec_status = ST_OK;
            end else begin
                dec_action = ACT_CHUNK;
                dec_start  = 1'b1;
                dec_hold   = hdr_a > START_PAY;
                dec_wr_len = (hdr_a > START_PAY) ? START_PAY_N : hdr_a[IDX_W-1:0];
                dec_rd_len = hdr_b;
                dec_base   = IDX_W'(START_HDR_BYTES);
            end
        end else begin
            if (len16 <= 16'(CONT_HDR_BYTES) || hdr_id != PID_XFER_CONT) begin
                dec_status = ST_UNEXPECTED;
            end else if (hdr_a != wr_done) begin
                dec_status = ST_UNEXPECTED;
            end else begin
                dec_action = ACT_CHUNK;
                dec_wr_len = cont_pay[IDX_W-1:0];
                dec_hold   = cont_sum < {1'b0, wr_total};
                dec_base   = IDX_W'(CONT_HDR_BYTES);
            end
        end
    end

endmodule

// File: rtl/pkt_rsp_build.sv
// Response former. On a fire strobe it registers either the 8-byte
// configuration answer or a 4-byte status answer, little-endian, byte 0 in
// the low bits. The strobe is a single-cycle pulse.
module pkt_rsp_build
    import pkt_bridge_pkg::*;
#(
    parameter int MAX_WR = 270,
    parameter int MAX_RD = 2045
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fire,
    input  logic        is_cfg,
    input  logic [15:0] code,
    output logic        rsp_valid,
    output logic [3:0]  rsp_len,
    output logic [63:0] rsp_data
);
    localparam logic [15:0] MAX_WR16 = 16'(MAX_WR);
    localparam logic [15:0] MAX_RD16 = 16'(MAX_RD);

    // Register the response and its strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_len   <= 4'd0;
            rsp_data  <= 64'd0;
        end else begin
            rsp_valid <= fire;
            if (fire) begin
                if (is_cfg) begin
                    rsp_len  <= 4'd8;
                    rsp_data <= {16'h0000, MAX_RD16, MAX_WR16, PID_CFG_RSP};
                end else begin
                    rsp_len  <= 4'd4;
                    rsp_data <= {32'h0, code, PID_RSP_START};
                end
            end
        end
    end

endmodule

// File: rtl/pkt_spi_bridge.sv
// Top of the packetized SPI bridge command engine. Collects a packet,
// evaluates it for one cycle, then either answers at once or issues a chunk
// to the SPI controller and waits for its completion. Holds the IDLE and
// WRITING protocol state, the total write count and the running offset.
// Assumes the host sends one packet at a time and watches rx_ready.
module pkt_spi_bridge
    import pkt_bridge_pkg::*;
#(
    parameter  int MAX_PKT = 64,
    parameter  int MAX_WR  = 270,
    parameter  int MAX_RD  = 2045,
    localparam int IDX_W   = $clog2(MAX_PKT),
    localparam int LEN_W   = $clog2(MAX_PKT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bridge_en,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_last,
    output logic             rx_ready,
    output logic             rsp_valid,
    output logic [3:0]       rsp_len,
    output logic [63:0]      rsp_data,
    output logic             chk_req,
    output logic [IDX_W-1:0] chk_wr_len,
    output logic [15:0]      chk_rd_len,
    output logic             chk_hold_cs,
    output logic [IDX_W-1:0] chk_base,
    input  logic             chk_done,
    input  logic [15:0]      chk_status,
    input  logic [IDX_W-1:0] spi_rd_idx,
    output logic [7:0]       spi_rd_byte
);
    phase_t           phase;
    proto_t           proto;
    logic [15:0]      wr_total;
    logic [15:0]      wr_done;
    logic             accept;
    logic [LEN_W-1:0] pkt_len;
    logic [15:0]      hdr_id, hdr_a, hdr_b;
    action_t          dec_action;
    logic [15:0]      dec_status;
    logic             dec_start;
    logic [IDX_W-1:0] dec_wr_len;
    logic [15:0]      dec_rd_len;
    logic             dec_hold;
    logic [IDX_W-1:0] dec_base;
    logic             rsp_fire;
    logic             rsp_cfg;
    logic [15:0]      rsp_code;

    // Bytes are taken only while collecting a packet
    assign rx_ready = (phase == PH_RECV);
    assign accept   = rx_valid && rx_ready;

    pkt_rx_buffer #(.MAX_PKT(MAX_PKT)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept),
        .wr_byte (rx_data),
        .wr_last (rx_last),
        .pkt_len (pkt_len),
        .hdr_id  (hdr_id),
        .hdr_a   (hdr_a),
        .hdr_b   (hdr_b),
        .rd_idx  (spi_rd_idx),
        .rd_byte (spi_rd_byte)
    );

    pkt_hdr_check #(.MAX_PKT(MAX_PKT), .MAX_WR(MAX_WR), .MAX_RD(MAX_RD)) u_chk_hdr (
        .enabled    (bridge_en),
        .proto      (proto),
        .pkt_len    (pkt_len),
        .hdr_id     (hdr_id),
        .hdr_a      (hdr_a),
        .hdr_b      (hdr_b),
        .wr_total   (wr_total),
        .wr_done    (wr_done),
        .dec_action (dec_action),
        .dec_status (dec_status),
        .dec_start  (dec_start),
        .dec_wr_len (dec_wr_len),
        .dec_rd_len (dec_rd_len),
        .dec_hold   (dec_hold),
        .dec_base   (dec_base)
    );

    // Choose when and what to answer
    always_comb begin
        rsp_fire = 1'b0;
        rsp_cfg  = 1'b0;
        rsp_code = ST_OK;
        if (phase == PH_EVAL && dec_action != ACT_CHUNK) begin
            rsp_fire = 1'b1;
            rsp_cfg  = (dec_action == ACT_CONFIG);
            rsp_code = dec_status;
        end else if (phase == PH_CHUNK && chk_done &&
                     (chk_status != ST_OK || !chk_hold_cs)) begin
            rsp_fire = 1'b1;
            rsp_code = chk_status;
        end
    end

    pkt_rsp_build #(.MAX_WR(MAX_WR), .MAX_RD(MAX_RD)) u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (rsp_fire),
        .is_cfg    (rsp_cfg),
        .code      (rsp_code),
        .rsp_valid (rsp_valid),
        .rsp_len   (rsp_len),
        .rsp_data  (rsp_data)
    );

    // Phase sequencing, protocol state, write tracking and chunk requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase       <= PH_RECV;
            proto       <= PS_IDLE;
            wr_total    <= 16'd0;
            wr_done     <= 16'd0;
            chk_req     <= 1'b0;
            chk_wr_len  <= '0;
            chk_rd_len  <= 16'd0;
            chk_hold_cs <= 1'b0;
            chk_base    <= '0;
        end else begin
            case (phase)
                PH_RECV: begin
                    if (accept && rx_last) begin
                        phase <= PH_EVAL;
                    end
                end
                PH_EVAL: begin
                    if (dec_action == ACT_CHUNK) begin
                        phase       <= PH_CHUNK;
                        chk_req     <= 1'b1;
                        chk_wr_len  <= dec_wr_len;
                        chk_rd_len  <= dec_rd_len;
                        chk_hold_cs <= dec_hold;
                        chk_base    <= dec_base;
                        if (dec_start) begin
                            wr_total <= hdr_a;
                            wr_done  <= 16'd0;
                        end
                    end else begin
                        phase <= PH_RECV;
                        if (dec_action == ACT_STATUS) begin
                            proto <= PS_IDLE;
                        end
                    end
                end
                PH_CHUNK: begin
                    if (chk_done) begin
                        chk_req <= 1'b0;
                        phase   <= PH_RECV;
                        if (chk_status != ST_OK) begin
                            proto <= PS_IDLE;
                        end else if (chk_hold_cs) begin
                            proto   <= PS_WRITING;
                            wr_done <= wr_done + 16'(chk_wr_len);
                        end else begin
                            proto <= PS_IDLE;
                        end
                    end
                end
                default: phase <= PH_RECV;
            endcase
        end
    end

endmodule

// File: rtl/pkt_spi_bridge_checker.sv
// Protocol checker for the bridge's ports: chunk handshake, intake lockout,
// response strobe and response layout. Attached by bind below.
module pkt_spi_bridge_checker #(
    parameter  int MAX_PKT = 64,
    parameter  int MAX_WR  = 270,
    parameter  int MAX_RD  = 2045,
    localparam int IDX_W   = $clog2(MAX_PKT)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_ready,
    input logic             rsp_valid,
    input logic [3:0]       rsp_len,
    input logic [63:0]      rsp_data,
    input logic             chk_req,
    input logic [IDX_W-1:0] chk_wr_len,
    input logic             chk_done
);

    assert_req_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_req && !chk_done) |=> chk_req);

    assert_req_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_req && chk_done) |=> !chk_req);

    assert_no_intake_R12: assert property (@(posedge clk) disable iff (!rst_n)
        chk_req |-> !rx_ready);

    assert_rsp_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_rsp_len_R13: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_len == 4'd4 || rsp_len == 4'd8));

    assert_cfg_layout_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_len == 4'd8) |->
        (rsp_data == {16'h0000, 16'(MAX_RD), 16'(MAX_WR), 16'h0001}));

    assert_status_layout_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_len == 4'd4) |->
        (rsp_data[15:0] == 16'h0005 && rsp_data[63:32] == 32'h0));

    assert_chunk_fits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        chk_req |-> (32'(chk_wr_len) <= MAX_PKT - 4));

endmodule

bind pkt_spi_bridge pkt_spi_bridge_checker #(
    .MAX_PKT(MAX_PKT), .MAX_WR(MAX_WR), .MAX_RD(MAX_RD)
) u_pkt_spi_bridge_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_ready   (rx_ready),
    .rsp_valid  (rsp_valid),
    .rsp_len    (rsp_len),
    .rsp_data   (rsp_data),
    .chk_req    (chk_req),
    .chk_wr_len (chk_wr_len),
    .chk_done   (chk_done)
);

// File: tb/pkt_spi_bridge_bench.sv
// Scoreboard bench: driver tasks push expected responses and chunks into
// queues; a response monitor and a SPI controller model pop and compare.
module pkt_spi_bridge_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bridge_en = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'd0;
    logic        rx_last = 1'b0;
    logic        rx_ready;
    logic        rsp_valid;
    logic [3:0]  rsp_len;
    logic [63:0] rsp_data;
    logic        chk_req;
    logic [5:0]  chk_wr_len;
    logic [15:0] chk_rd_len;
    logic        chk_hold_cs;
    logic [5:0]  chk_base;
    logic        chk_done = 1'b0;
    logic [15:0] chk_status = 16'd0;
    logic [5:0]  spi_rd_idx = 6'd0;
    logic [7:0]  spi_rd_byte;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    logic [7:0] pkt [64];

    logic [63:0] exp_data [$];
    logic [3:0]  exp_len  [$];
    string       exp_tag  [$];
    int          c_wr [$];
    int          c_rd [$];
    logic        c_hold [$];
    int          c_base [$];
    logic [7:0]  c_first [$];
    logic [15:0] c_stat [$];
    string       c_tag [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_spi_bridge u_pkt_spi_bridge (
        .clk(clk), .rst_n(rst_n), .bridge_en(bridge_en),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready),
        .rsp_valid(rsp_valid), .rsp_len(rsp_len), .rsp_data(rsp_data),
        .chk_req(chk_req), .chk_wr_len(chk_wr_len), .chk_rd_len(chk_rd_len),
        .chk_hold_cs(chk_hold_cs), .chk_base(chk_base), .chk_done(chk_done),
        .chk_status(chk_status), .spi_rd_idx(spi_rd_idx), .spi_rd_byte(spi_rd_byte)
    );

    task automatic check(input logic ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Watchdog: a hung run is a failed check
    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000) begin
            errors++;
            checks++;
            $display("FAIL R12 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic put16(input int pos, input int v);
        pkt[pos]   = v[7:0];
        pkt[pos+1] = v[15:8];
    endtask

    task automatic send(input int n);
        while (!rx_ready) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            rx_valid = 1'b1;
            rx_data  = pkt[i];
            rx_last  = (i == n - 1);
            @(negedge clk);
        end
        rx_valid = 1'b0;
        rx_last  = 1'b0;
    endtask

    task automatic send_start(input int wr, input int rd, input int pay, input logic [7:0] seed);
        put16(0, 2); put16(2, wr); put16(4, rd);
        for (int i = 0; i < pay; i++) pkt[6+i] = 8'(seed + 8'(i));
        send(6 + pay);
    endtask

    task automatic send_cont(input int idx, input int pay, input logic [7:0] seed);
        put16(0, 3); put16(2, idx);
        for (int i = 0; i < pay; i++) pkt[4+i] = 8'(seed + 8'(i));
        send(4 + pay);
    endtask

    task automatic send_id(input int id, input int n);
        put16(0, id);
        pkt[2] = 8'h00;
        send(n);
    endtask

    task automatic exp_status(input logic [15:0] code, input string tag);
        exp_data.push_back({32'h0, code, 16'h0005});
        exp_len.push_back(4'd4);
        exp_tag.push_back(tag);
    endtask

    task automatic exp_cfg(input string tag);
        exp_data.push_back({16'h0000, 16'd2045, 16'd270, 16'h0001});
        exp_len.push_back(4'd8);
        exp_tag.push_back(tag);
    endtask

    task automatic exp_chunk(input int wr, input int rd, input logic hold, input int base,
                             input logic [7:0] first, input logic [15:0] st, input string tag);
        c_wr.push_back(wr); c_rd.push_back(rd); c_hold.push_back(hold);
        c_base.push_back(base); c_first.push_back(first); c_stat.push_back(st);
        c_tag.push_back(tag);
    endtask

    task automatic drain();
        for (int i = 0; i < 200; i++) begin
            if (exp_data.size() == 0 && c_wr.size() == 0 && rx_ready && !chk_req) break;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    // Response monitor
    initial begin
        logic prev = 1'b0;
        forever begin
            @(negedge clk);
            if (rsp_valid) begin
                check(!prev, "R13 strobe longer than one cycle", 64'(prev), 64'd0);
                if (exp_data.size() == 0) begin
                    check(1'b0, "R13 unexpected response", rsp_data, 64'd0);
                end else begin
                    logic [63:0] d;
                    logic [3:0]  l;
                    string       t;
                    d = exp_data.pop_front();
                    l = exp_len.pop_front();
                    t = exp_tag.pop_front();
                    check(rsp_len == l && rsp_data == d, t, {rsp_len, rsp_data[59:0]},
                          {l, d[59:0]});
                end
            end
            prev = rsp_valid;
        end
    end

    // SPI controller model
    initial begin
        forever begin
            @(negedge clk);
            if (chk_req) begin
                logic [15:0] st;
                st = 16'd0;
                check(!rx_ready, "R12 intake open during chunk", 64'(rx_ready), 64'd0);
                if (c_wr.size() == 0) begin
                    check(1'b0, "R12 unexpected chunk", 64'(chk_wr_len), 64'd0);
                end else begin
                    int w, r, b;
                    logic h;
                    logic [7:0] f;
                    string t;
                    w = c_wr.pop_front(); r = c_rd.pop_front(); h = c_hold.pop_front();
                    b = c_base.pop_front(); f = c_first.pop_front(); st = c_stat.pop_front();
                    t = c_tag.pop_front();
                    spi_rd_idx = chk_base;
                    #1;
                    if (w == 0) f = spi_rd_byte;
                    check(32'(chk_wr_len) == w && 32'(chk_rd_len) == r && chk_hold_cs == h &&
                          32'(chk_base) == b && spi_rd_byte == f, t,
                          {8'(chk_wr_len), chk_rd_len, 7'd0, chk_hold_cs, 8'(chk_base), spi_rd_byte},
                          {8'(w), 16'(r), 7'd0, h, 8'(b), f});
                end
                repeat (2) @(negedge clk);
                chk_status = st;
                chk_done   = 1'b1;
                @(negedge clk);
                chk_done   = 1'b0;
                chk_status = 16'd0;
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(rx_ready && !rsp_valid && !chk_req, "R1 reset state",
              {rx_ready, rsp_valid, chk_req}, 3'b100);

        // R2 configuration query
        exp_cfg("R2 config answer");
        send_id(0, 2); drain();

        // R3 framing faults in IDLE
        exp_status(16'h000A, "R3 config id with length 3");
        send_id(0, 3); drain();
        exp_status(16'h000A, "R3 restart id in IDLE");
        send_id(4, 2); drain();
        exp_status(16'h8000, "R3 one-byte packet");
        send_id(0, 1); drain();
        exp_status(16'h000A, "R3 start shorter than 6");
        send_id(2, 5); drain();

        // R4 read count limits and priority
        exp_status(16'h0004, "R4 read 2046 with write 300");
        send_start(300, 2046, 0, 8'h00); drain();
        exp_chunk(0, 2045, 1'b0, 6, 8'h00, 16'd0, "R4 read 2045 accepted");
        exp_status(16'h0000, "R6 read-only success");
        send_start(0, 2045, 0, 8'h00); drain();

        // R5 write count faults
        exp_status(16'h0003, "R5 write 271");
        send_start(271, 0, 0, 8'h00); drain();
        exp_status(16'h0003, "R5 length mismatch");
        send_start(10, 0, 9, 8'h11); drain();
        exp_status(16'h0003, "R5 long write with read");
        send_start(59, 1, 58, 8'h11); drain();

        // R6 single-chunk transactions
        exp_chunk(4, 8, 1'b0, 6, 8'h40, 16'd0, "R6 short write then read");
        exp_status(16'h0000, "R6 status after chunk");
        send_start(4, 8, 4, 8'h40); drain();
        exp_chunk(58, 0, 1'b0, 6, 8'h50, 16'd0, "R6 write of exactly 58");
        exp_status(16'h0000, "R6 status after 58");
        send_start(58, 0, 58, 8'h50); drain();
        exp_status(16'h0000, "R6 empty request");
        send_start(0, 0, 0, 8'h00); drain();

        // R7 R8 multi-packet write of 130
        exp_chunk(58, 0, 1'b1, 6, 8'h60, 16'd0, "R7 first chunk held");
        send_start(130, 0, 58, 8'h60); drain();
        exp_chunk(60, 0, 1'b1, 4, 8'h70, 16'd0, "R8 middle chunk held");
        send_cont(58, 60, 8'h70); drain();
        exp_chunk(12, 0, 1'b0, 4, 8'h90, 16'd0, "R8 final chunk released");
        exp_status(16'h0000, "R8 completion status");
        send_cont(118, 12, 8'h90); drain();

        // R7 R8 boundary: 59-byte write
        exp_chunk(58, 0, 1'b1, 6, 8'h01, 16'd0, "R7 59-byte first chunk");
        send_start(59, 0, 58, 8'h01); drain();
        exp_chunk(1, 0, 1'b0, 4, 8'hC3, 16'd0, "R8 one-byte tail");
        exp_status(16'h0000, "R8 tail completion");
        send_cont(58, 1, 8'hC3); drain();

        // R9 faults in WRITING, each followed by proof of IDLE
        exp_chunk(58, 0, 1'b1, 6, 8'h20, 16'd0, "R7 setup index fault");
        send_start(100, 0, 58, 8'h20); drain();
        exp_status(16'h0008, "R9 wrong data index");
        send_cont(50, 10, 8'h00); drain();
        exp_cfg("R9 back in IDLE after index fault");
        send_id(0, 2); drain();

        exp_chunk(58, 0, 1'b1, 6, 8'h20, 16'd0, "R7 setup stray start");
        send_start(100, 0, 58, 8'h20); drain();
        exp_status(16'h0008, "R9 start while writing");
        send_start(4, 0, 4, 8'h00); drain();

        exp_chunk(58, 0, 1'b1, 6, 8'h20, 16'd0, "R7 setup empty continue");
        send_start(100, 0, 58, 8'h20); drain();
        exp_status(16'h0008, "R9 continue without payload");
        send_cont(58, 0, 8'h00); drain();

        exp_chunk(58, 0, 1'b1, 6, 8'h20, 16'd0, "R7 setup restart id");
        send_start(100, 0, 58, 8'h20); drain();
        exp_status(16'h0008, "R9 restart id while writing");
        send_id(4, 2); drain();

        // R10 controller faults
        exp_chunk(4, 0, 1'b0, 6, 8'h33, 16'h0001, "R10 single chunk fault");
        exp_status(16'h0001, "R10 fault reported");
        send_start(4, 0, 4, 8'h33); drain();
        exp_chunk(58, 0, 1'b1, 6, 8'h20, 16'h8123, "R10 first chunk fault");
        exp_status(16'h8123, "R10 first chunk fault reported");
        send_start(100, 0, 58, 8'h20); drain();
        exp_status(16'h000A, "R10 continue after fault seen in IDLE");
        send_cont(58, 10, 8'h00); drain();

        // R11 disabled bridge
        bridge_en = 1'b0;
        exp_status(16'h0005, "R11 config while disabled");
        send_id(0, 2); drain();
        exp_status(16'h0005, "R11 start while disabled");
        send_start(4, 0, 4, 8'h00); drain();
        bridge_en = 1'b1;
        exp_chunk(58, 0, 1'b1, 6, 8'h20, 16'd0, "R11 setup write");
        send_start(100, 0, 58, 8'h20); drain();
        bridge_en = 1'b0;
        exp_status(16'h0005, "R11 continue while disabled");
        send_cont(58, 42, 8'h00); drain();
        bridge_en = 1'b1;
        exp_status(16'h000A, "R11 continue after re-enable seen in IDLE");
        send_cont(58, 42, 8'h00); drain();
        exp_cfg("R11 config after re-enable");
        send_id(0, 2); drain();

        repeat (10) @(negedge clk);
        check(exp_data.size() == 0, "R13 responses missing", 64'(exp_data.size()), 64'd0);
        check(c_wr.size() == 0, "R12 chunks missing", 64'(c_wr.size()), 64'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule